// File: doc/BRIEF.md
# External Memory Strobe Generator

This block turns access requests from a processor core into the active-low control strobes of an external 16-bit memory bus. A request gives the kind of access (code fetch, data read or data write), the byte lanes of a write, the address segment and a wait-state count. The block then runs a fixed setup, strobe and hold sequence. During that sequence it drives the program-memory select, the data-memory select, the read strobe, and separate write strobes for the low byte and the high byte. All strobe outputs come straight from flip-flops, so they carry no glitches.

The data-memory select has two behaviours, chosen by a mode bit that firmware writes. In the low-power behaviour the select is low only while a read strobe or a write strobe is low. In the fast behaviour it is low for the whole access. The topmost address segment never selects the data memory. A power-fail input that goes low locks the data select and both write strobes high, and they stay high until reset. An access that is suppressed this way still runs to completion with its normal timing.

Top module: `mem_strobe_gen`

## Requirements
- R1: After synchronous reset, every strobe output is high, `busy` and `done` are low, and the mode bit selects the low-power behaviour (value 0).
- R2: An accepted access drives its outputs from the edge that accepts it. The access has 1 setup cycle, then `req_wait`+1 strobe cycles, then 1 hold cycle (`done` high only in that cycle). After the hold cycle the block is idle. `busy` is high from setup through hold.
- R3: `pm_cs_n` is low from setup through hold of a code fetch (`req_kind`=0) and high at every other time.
- R4: `rd_n` is low during the strobe cycles of a code fetch or a data read (`req_kind`=1) and high at every other time. It is never low together with a write strobe.
- R5: `wrl_n` is low during the strobe cycles of a data write (`req_kind`=2) whose `req_be[0]` is 1. This covers low-byte writes and word writes.
- R6: `wrh_n` is low during the strobe cycles of a data write whose `req_be[1]` is 1. This covers high-byte writes and word writes.
- R7: `dm_cs_n` can go low only for data reads and data writes whose segment is not the all-ones value. For segment all-ones, both write strobes also stay high. It is never low together with `pm_cs_n`.
- R8: In low-power mode (mode 0), `dm_cs_n` is low only in cycles where `rd_n`, `wrl_n` or `wrh_n` is low.
- R9: In fast mode (mode 1), `dm_cs_n` is low from setup through hold of every data access that is allowed to select.
- R10: `mode_we` loads `mode_fast` into the mode bit at the clock edge. Each access uses the mode bit value at its acceptance, so a change during an access does not affect that access.
- R11: At the first edge that samples `pwr_fail_n` low, `dm_cs_n`, `wrl_n` and `wrh_n` go high. From then on they stay high until reset, even if `pwr_fail_n` returns high. `pm_cs_n` and `rd_n` keep working.
- R12: An access whose data select or write strobes are suppressed (top segment or power-fail) still completes with the R2 timing.
- R13: A request is accepted only when `busy` is low and `req_kind` is not 3. Other requests are ignored and leave the strobes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write, 3 reserved |
| req_be | input | 2 | Write lane enables: bit 0 low byte, bit 1 high byte |
| req_seg | input | SEG_W | Address segment of the access |
| req_wait | input | WS_W | Extra strobe cycles (wait states) |
| mode_we | input | 1 | Load the mode bit |
| mode_fast | input | 1 | Mode value: 0 low-power, 1 fast |
| pwr_fail_n | input | 1 | Power-fail input, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | Hold cycle of the access |
| pm_cs_n | output | 1 | Program-memory select, active low |
| dm_cs_n | output | 1 | Data-memory select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wrl_n | output | 1 | Low-byte write strobe, active low |
| wrh_n | output | 1 | High-byte write strobe, active low |

## Verification
The power-fail lockout and an in-flight word write can act in the same cycle. The bench provokes this by dropping `pwr_fail_n` partway through the strobe phase of a fast-mode write. It then judges that the data select and both write strobes rise at the very next edge, that `busy` still runs to the hold cycle, and that later accesses stay locked after the input recovers. A mode-bit write that lands during an access is judged the same way: the running access keeps its old behaviour and the next access takes the new one.

// File: rtl/mstb_pkg.sv
package mstb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    AK_CODE   = 2'd0,
    AK_DREAD  = 2'd1,
    AK_DWRITE = 2'd2,
    AK_NONE   = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] be;
    logic       top_seg;
    logic       fast;
  } acc_t;

endpackage

// File: rtl/mstb_seq.sv
module mstb_seq
  import mstb_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WS_W-1:0] ws,
  output phase_e          phase_q,
  output phase_e          phase_nxt,
  output logic            busy,
  output logic            done
);

  logic [WS_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    phase_nxt = phase_q;
    cnt_nxt   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_nxt = PH_SETUP;
          cnt_nxt   = ws;
        end
      end
      PH_SETUP:  phase_nxt = PH_STROBE;
      PH_STROBE: begin
        if (cnt_q == '0) phase_nxt = PH_HOLD;
        else             cnt_nxt   = cnt_q - 1'b1;
      end
      PH_HOLD:   phase_nxt = PH_IDLE;
      default:   phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= cnt_nxt;
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign done = (phase_q == PH_HOLD);

  // R2
  setup_to_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SETUP) |=> (phase_q == PH_STROBE));

  // R2
  hold_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HOLD) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/mstb_dec.sv
module mstb_dec
  import mstb_pkg::*;
(
  input  acc_t   acc,
  input  phase_e ph,
  input  logic   lock,
  output logic   pm_a,
  output logic   rd_a,
  output logic   dm_a,
  output logic   wl_a,
  output logic   wh_a
);

  logic act, stb, is_data, safe;

  always_comb begin
    act     = (ph != PH_IDLE);
    stb     = (ph == PH_STROBE);
    is_data = (acc.kind == AK_DREAD) || (acc.kind == AK_DWRITE);
    safe    = !acc.top_seg && !lock;

    pm_a = (acc.kind == AK_CODE) && act;
    rd_a = ((acc.kind == AK_CODE) || (acc.kind == AK_DREAD)) && stb;
    wl_a = (acc.kind == AK_DWRITE) && acc.be[0] && safe && stb;
    wh_a = (acc.kind == AK_DWRITE) && acc.be[1] && safe && stb;

    if (acc.fast) dm_a = is_data && safe && act;
    else          dm_a = is_data && safe && (rd_a || wl_a || wh_a);
  end

endmodule

// File: rtl/mstb_out.sv
module mstb_out (
  input  logic clk,
  input  logic rst,
  input  logic pwr_fail_n,
  input  logic fast_nxt,
  input  logic pm_a,
  input  logic rd_a,
  input  logic dm_a,
  input  logic wl_a,
  input  logic wh_a,
  output logic lock_nxt,
  output logic pm_cs_n,
  output logic dm_cs_n,
  output logic rd_n,
  output logic wrl_n,
  output logic wrh_n
);

  logic lock_q;
  logic fast_q;

  assign lock_nxt = lock_q || !pwr_fail_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= 1'b0;
      fast_q  <= 1'b0;
      pm_cs_n <= 1'b1;
      dm_cs_n <= 1'b1;
      rd_n    <= 1'b1;
      wrl_n   <= 1'b1;
      wrh_n   <= 1'b1;
    end else begin
      lock_q  <= lock_nxt;
      fast_q  <= fast_nxt;
      pm_cs_n <= !pm_a;
      dm_cs_n <= !(dm_a && !lock_nxt);
      rd_n    <= !rd_a;
      wrl_n   <= !(wl_a && !lock_nxt);
      wrh_n   <= !(wh_a && !lock_nxt);
    end
  end

  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  // R11
  lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> (dm_cs_n && wrl_n && wrh_n));

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (wrl_n && wrh_n));

  // R7
  cs_excl_chk: assert property (@(posedge clk) disable iff (rst)
    pm_cs_n || dm_cs_n);

  // R8
  lowpow_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!dm_cs_n && !fast_q) |-> (!rd_n || !wrl_n || !wrh_n));

endmodule

// File: rtl/mem_strobe_gen.sv
module mem_strobe_gen
  import mstb_pkg::*;
#(
  parameter int   SEG_W    = 4,
  parameter int   WS_W     = 3,
  parameter logic MODE_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_be,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [WS_W-1:0]  req_wait,
  input  logic             mode_we,
  input  logic             mode_fast,
  input  logic             pwr_fail_n,
  output logic             busy,
  output logic             done,
  output logic             pm_cs_n,
  output logic             dm_cs_n,
  output logic             rd_n,
  output logic             wrl_n,
  output logic             wrh_n
);

  logic   mode_q;
  acc_t   acc_q, acc_in, acc_nxt;
  logic   start;
  phase_e phase_q, phase_nxt;
  logic   lock_nxt;
  logic   pm_a, rd_a, dm_a, wl_a, wh_a;

  assign start = req_valid && !busy && (req_kind != AK_NONE);

  always_comb begin
    acc_in.kind    = kind_e'(req_kind);
    acc_in.be      = req_be;
    acc_in.top_seg = &req_seg;
    acc_in.fast    = mode_q;
    acc_nxt        = start ? acc_in : acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RST;
      acc_q  <= '{kind: AK_NONE, be: 2'b00, top_seg: 1'b0, fast: 1'b0};
    end else begin
      if (mode_we) mode_q <= mode_fast;
      acc_q <= acc_nxt;
    end
  end

  mstb_seq #(.WS_W(WS_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ws        (req_wait),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .busy      (busy),
    .done      (done)
  );

  mstb_dec u_dec (
    .acc  (acc_nxt),
    .ph   (phase_nxt),
    .lock (lock_nxt),
    .pm_a (pm_a),
    .rd_a (rd_a),
    .dm_a (dm_a),
    .wl_a (wl_a),
    .wh_a (wh_a)
  );

  mstb_out u_out (
    .clk        (clk),
    .rst        (rst),
    .pwr_fail_n (pwr_fail_n),
    .fast_nxt   (acc_nxt.fast),
    .pm_a       (pm_a),
    .rd_a       (rd_a),
    .dm_a       (dm_a),
    .wl_a       (wl_a),
    .wh_a       (wh_a),
    .lock_nxt   (lock_nxt),
    .pm_cs_n    (pm_cs_n),
    .dm_cs_n    (dm_cs_n),
    .rd_n       (rd_n),
    .wrl_n      (wrl_n),
    .wrh_n      (wrh_n)
  );

  // R2
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wrl_n || !wrh_n || !pm_cs_n || !dm_cs_n) |-> busy);

  // R13
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

endmodule

// File: tb/mem_strobe_gen_test.sv
`timescale 1ns/1ps
module mem_strobe_gen_test;

  localparam int SEG_W = 4;
  localparam int WS_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [1:0] req_be = 2'd0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [WS_W-1:0] req_wait = '0;
  logic mode_we = 1'b0;
  logic mode_fast = 1'b0;
  logic pwr_fail_n = 1'b1;
  logic busy, done, pm_cs_n, dm_cs_n, rd_n, wrl_n, wrh_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mem_strobe_gen #(.SEG_W(SEG_W), .WS_W(WS_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_be(req_be), .req_seg(req_seg), .req_wait(req_wait),
    .mode_we(mode_we), .mode_fast(mode_fast), .pwr_fail_n(pwr_fail_n),
    .busy(busy), .done(done), .pm_cs_n(pm_cs_n), .dm_cs_n(dm_cs_n),
    .rd_n(rd_n), .wrl_n(wrl_n), .wrh_n(wrh_n)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected {busy,done,pm,dm,rd,wl,wh} for cycle c after acceptance.
  function automatic logic [6:0] expv(int kind, int be, int seg, int fast,
                                      int lock, int c, int ws);
    int ph;
    logic act, stb, hit, rdx, wlx, whx, dmx;
    if (c == 0) ph = 1;
    else if (c <= ws + 1) ph = 2;
    else if (c == ws + 2) ph = 3;
    else ph = 0;
    act = (ph != 0);
    stb = (ph == 2);
    hit = (kind != 0) && (seg != 15) && (lock == 0);
    rdx = (kind == 0 || kind == 1) && stb;
    wlx = (kind == 2) && be[0] && hit && stb;
    whx = (kind == 2) && be[1] && hit && stb;
    if (fast != 0) dmx = hit && act;
    else           dmx = hit && (rdx || wlx || whx);
    return {act, (ph == 3), !((kind == 0) && act), !dmx, !rdx, !wlx, !whx};
  endfunction

  task automatic compare(input logic [6:0] e, input string dmtag);
    check(busy == e[6], "R2 busy", busy, e[6]);
    check(done == e[5], "R2 done", done, e[5]);
    check(pm_cs_n == e[4], "R3 pm_cs_n", pm_cs_n, e[4]);
    check(dm_cs_n == e[3], dmtag, dm_cs_n, e[3]);
    check(rd_n == e[2], "R4 rd_n", rd_n, e[2]);
    check(wrl_n == e[1], "R5 wrl_n", wrl_n, e[1]);
    check(wrh_n == e[0], "R6 wrh_n", wrh_n, e[0]);
  endtask

  task automatic set_mode(input logic f);
    mode_we = 1'b1; mode_fast = f;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // Called at a negedge; returns at the negedge of the idle cycle.
  task automatic access(input int kind, input int be, input int seg, input int ws,
                        input int fast, input int lock, input string dmtag);
    req_valid = 1'b1; req_kind = kind[1:0]; req_be = be[1:0];
    req_seg = seg[SEG_W-1:0]; req_wait = ws[WS_W-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c <= ws + 3; c++) begin
      compare(expv(kind, be, seg, fast, lock, c, ws), dmtag);
      if (c < ws + 3) @(negedge clk);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int segs[4];
    int wss[3];
    segs = '{0, 7, 14, 15};
    wss  = '{0, 1, 3};
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check(pm_cs_n && dm_cs_n && rd_n && wrl_n && wrh_n, "R1 strobes high",
          {pm_cs_n, dm_cs_n, rd_n, wrl_n, wrh_n}, 31);
    check(!busy && !done, "R1 idle", {busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: default low-power mode, dm high in setup of a data read
    access(1, 0, 0, 1, 0, 0, "R1 default mode dm_cs_n");

    // Sweep: R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int f = 0; f < 2; f++) begin
      set_mode(f[0]);
      for (int k = 0; k < 3; k++)
        for (int b = 0; b < 4; b++)
          for (int s = 0; s < 4; s++)
            for (int w = 0; w < 3; w++)
              access(k, b, segs[s], wss[w], f, 0,
                     (segs[s] == 15) ? "R7 dm_cs_n" : (f != 0 ? "R9 dm_cs_n" : "R8 dm_cs_n"));
    end

    // R10: mode change during an access does not affect it
    set_mode(1'b0);
    req_valid = 1'b1; req_kind = 2'd1; req_be = 2'd0; req_seg = '0; req_wait = 3'd2;
    @(negedge clk);
    req_valid = 1'b0;
    mode_we = 1'b1; mode_fast = 1'b1;
    for (int c = 0; c <= 5; c++) begin
      compare(expv(1, 0, 0, 0, 0, c, 2), "R10 dm_cs_n running access");
      @(negedge clk);
      mode_we = 1'b0;
    end
    access(1, 0, 0, 2, 1, 0, "R10 dm_cs_n next access");

    // R13: requests during busy and reserved kind are ignored
    req_valid = 1'b1; req_kind = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    check(!busy && pm_cs_n && rd_n && dm_cs_n, "R13 reserved kind",
          {busy, pm_cs_n, rd_n, dm_cs_n}, 7);
    req_valid = 1'b1; req_kind = 2'd1; req_be = 2'd0; req_seg = '0; req_wait = 3'd3;
    @(negedge clk);
    req_kind = 2'd0;
    for (int c = 0; c <= 6; c++) begin
      check(pm_cs_n == 1'b1, "R13 pm_cs_n while busy", pm_cs_n, 1);
      compare(expv(1, 0, 0, 1, 0, c, 3), "R13 dm_cs_n");
      if (c == 5) req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;

    // R11 R12: power-fail during fast word write
    req_valid = 1'b1; req_kind = 2'd2; req_be = 2'd3; req_seg = '0; req_wait = 3'd3;
    @(negedge clk);
    req_valid = 1'b0;
    compare(expv(2, 3, 0, 1, 0, 0, 3), "R9 dm_cs_n");
    @(negedge clk);
    compare(expv(2, 3, 0, 1, 0, 1, 3), "R9 dm_cs_n");
    pwr_fail_n = 1'b0;
    @(negedge clk);
    for (int c = 2; c <= 6; c++) begin
      compare(expv(2, 3, 0, 1, 1, c, 3), "R11 dm_cs_n locked");
      check(busy == (c <= 5), "R12 completes under lock", busy, (c <= 5));
      if (c == 3) pwr_fail_n = 1'b1;
      if (c < 6) @(negedge clk);
    end
    access(2, 3, 0, 1, 1, 1, "R11 dm_cs_n sticky");
    access(1, 0, 3, 0, 1, 1, "R11 dm_cs_n sticky read");
    access(0, 0, 3, 1, 1, 1, "R11 code fetch still works");
    do_reset();
    access(2, 3, 0, 1, 0, 0, "R1 lock cleared dm_cs_n");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule